// File: doc/BRIEF.md
# Video control line transition limiter

This block conditions the three low-rate video control lines (data enable, horizontal sync and vertical sync) on the pixel clock before they are packed into a serial link. Those lines are expected to change only rarely. Any burst of edges is treated as noise, and forwarding that noise would corrupt the picture at the far end. Each line gets its own transition budget inside a window of pixel clocks. An edge over the budget is discarded, and a sticky flag records the loss.

Data enable and horizontal sync share one treatment. An optional qualifier, turned on by `glitch_en`, rejects any level that is not seen on three consecutive clocks. Vertical sync is treated more strictly. A new vertical-sync level must persist for a long minimum time before it is accepted, and only one vertical-sync edge may pass per window. All outputs are registered. Software clears the drop flags by pulsing `drop_clr`, one bit per line.

Top module: `ctl_line_filter`

## Requirements
- R1: De and hs each forward at most 2 transitions inside a window of 130 clock edges. A window opens on a forwarded transition when no window is open. It covers that edge and the next 129 edges. Vs forwards at most 1 transition per window.
- R2: With `glitch_en`=1, a de or hs level is forwarded only once it has been sampled on 3 consecutive clock edges. A level that lasts 1 or 2 clocks never reaches the output.
- R3: With `glitch_en`=0, de and hs have no minimum width. A level present for a single clock is forwarded, subject to R1.
- R4: With `glitch_en`=0, de_o and hs_o take a new level on the edge that first samples it. With `glitch_en`=1, they take it on the edge that samples it for the third consecutive time.
- R5: Vs_o takes a new level only on the edge that samples that level on vs_i for the 130th consecutive time. A vs level that lasts 129 clocks or fewer is never forwarded. Vs is never affected by `glitch_en`.
- R6: A transition beyond the budget is discarded and the output keeps its last forwarded level. A later return of the input to that held level counts as no transition and uses no budget.
- R7: `drop_flag` bit 0 belongs to de, bit 1 to hs and bit 2 to vs. A bit is set by the edge at which a transition of its line is discarded. It stays set until reset, or until an edge that samples the matching `drop_clr` bit high. If a set and a clear fall on the same edge, the set wins.
- R8: While `rst` is high, all three outputs are low, all flags are clear and no window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| glitch_en | input | 1 | Enables the 3-clock minimum-width qualifier on de and hs |
| drop_clr | input | 3 | Write-one-to-clear pulses for the drop flags (bit 0 de, 1 hs, 2 vs) |
| de_i | input | 1 | Raw data enable |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| de_o | output | 1 | Filtered data enable |
| hs_o | output | 1 | Filtered horizontal sync |
| vs_o | output | 1 | Filtered vertical sync |
| drop_flag | output | 3 | Sticky discarded-transition flags (bit 0 de, 1 hs, 2 vs) |

## Verification
The bench drives edges into the last edge of an open window and checks that they are dropped. A design with an off-by-one window would forward them instead. It also checks that the first edge after the window is accepted. It sends 2-clock and 3-clock de/hs pulses with the qualifier on, because a qualifier one sample short or one sample long passes the glitch or swallows the legal pulse. It sends a vertical-sync level held for 129 clocks, then one held for exactly 130, and checks that the output changes on the exact edge. It pulses a clear on the same edge as a drop, returns a dropped input to its held level, and checks that neither clears the flag nor spends budget. A behavioural model, compared on every clock over long random runs in both qualifier modes, catches any remaining mismatch in the budget bookkeeping.

// File: rtl/ctl_line_filter_pkg.sv
package ctl_line_filter_pkg;
  localparam int NUM_LINES = 3;
  localparam int NUM_FAST  = 2;

  typedef enum logic [1:0] {
    LINE_DE = 2'd0,
    LINE_HS = 2'd1,
    LINE_VS = 2'd2
  } line_e;
endpackage

// File: rtl/ctl_glitch_qual.sv
// Minimum-width qualifier for a fast control line. The result is
// combinational so that the budget stage register is the only delay
// added after the last required sample.
module ctl_glitch_qual #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic cand
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist;
  logic          hold;
  logic          steady;

  always_comb begin
    steady = (hist == {HW{din}});
    if (!en)
      cand = din;
    else if (steady)
      cand = din;
    else
      cand = hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      hold <= 1'b0;
    end else begin
      hist <= {hist[HW-2:0], din};
      hold <= cand;
    end
  end
endmodule

// File: rtl/ctl_hold_qual.sv
// Persistence qualifier for the slow line: a new level is accepted on
// the MIN-th consecutive sample of it.
module ctl_hold_qual #(
  parameter int MIN = 130
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic cand
);
  localparam int CW = $clog2(MIN);

  logic [CW-1:0] run;
  logic          acc;
  logic          take;

  always_comb begin
    take = (din != acc) && (run == CW'(MIN - 1));
    cand = take ? din : acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
      acc <= 1'b0;
    end else if (din == acc) begin
      run <= '0;
    end else if (take) begin
      run <= '0;
      acc <= din;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_line_budget.sv
// Per-line transition budget over a window that opens on demand.
module ctl_line_budget #(
  parameter int WIN    = 130,
  parameter int BUDGET = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cand,
  input  logic clr,
  output logic lvl,
  output logic flag
);
  localparam int TW = $clog2(WIN);
  localparam int UW = $clog2(BUDGET + 1);

  logic          cprev;
  logic          active;
  logic [TW-1:0] timer;
  logic [UW-1:0] used;
  logic          expire, live, change, room, fwd, drop;

  always_comb begin
    expire = active && (timer == TW'(WIN - 1));
    live   = active && !expire;
    change = (cand != cprev) && (cand != lvl);
    room   = !live || (used < UW'(BUDGET));
    fwd    = change && room;
    drop   = change && !room;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cprev  <= 1'b0;
      lvl    <= 1'b0;
      flag   <= 1'b0;
      active <= 1'b0;
      timer  <= '0;
      used   <= '0;
    end else begin
      cprev <= cand;
      if (fwd)
        lvl <= cand;
      flag <= drop | (flag & ~clr);
      if (fwd && !live) begin
        active <= 1'b1;
        timer  <= '0;
        used   <= UW'(1);
      end else if (live) begin
        timer <= timer + 1'b1;
        if (fwd)
          used <= used + 1'b1;
      end else begin
        active <= 1'b0;
        timer  <= '0;
        used   <= '0;
      end
    end
  end
endmodule

// File: rtl/ctl_line_filter.sv
module ctl_line_filter
  import ctl_line_filter_pkg::*;
#(
  parameter int WIN_LEN     = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1,
  parameter int GLITCH_LEN  = 3,
  parameter int VS_MIN      = 130
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glitch_en,
  input  logic [NUM_LINES-1:0] drop_clr,
  input  logic                 de_i,
  input  logic                 hs_i,
  input  logic                 vs_i,
  output logic                 de_o,
  output logic                 hs_o,
  output logic                 vs_o,
  output logic [NUM_LINES-1:0] drop_flag
);
  logic [NUM_FAST-1:0]  fast_raw;
  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] lvl;

  assign fast_raw[LINE_DE] = de_i;
  assign fast_raw[LINE_HS] = hs_i;

  for (genvar g = 0; g < NUM_FAST; g++) begin : g_fast
    ctl_glitch_qual #(.LEN(GLITCH_LEN)) u_qual (
      .clk  (clk),
      .rst  (rst),
      .en   (glitch_en),
      .din  (fast_raw[g]),
      .cand (cand[g])
    );

    ctl_line_budget #(.WIN(WIN_LEN), .BUDGET(FAST_BUDGET)) u_budget (
      .clk  (clk),
      .rst  (rst),
      .cand (cand[g]),
      .clr  (drop_clr[g]),
      .lvl  (lvl[g]),
      .flag (drop_flag[g])
    );
  end

  ctl_hold_qual #(.MIN(VS_MIN)) u_vs_qual (
    .clk  (clk),
    .rst  (rst),
    .din  (vs_i),
    .cand (cand[LINE_VS])
  );

  ctl_line_budget #(.WIN(WIN_LEN), .BUDGET(SLOW_BUDGET)) u_vs_budget (
    .clk  (clk),
    .rst  (rst),
    .cand (cand[LINE_VS]),
    .clr  (drop_clr[LINE_VS]),
    .lvl  (lvl[LINE_VS]),
    .flag (drop_flag[LINE_VS])
  );

  assign de_o = lvl[LINE_DE];
  assign hs_o = lvl[LINE_HS];
  assign vs_o = lvl[LINE_VS];
endmodule

// File: rtl/ctl_line_filter_chk.sv
module ctl_line_filter_chk #(
  parameter int GLITCH_LEN = 3,
  parameter int VS_MIN     = 130
) (
  input logic       clk,
  input logic       rst,
  input logic       glitch_en,
  input logic [2:0] drop_clr,
  input logic       de_i,
  input logic       hs_i,
  input logic       vs_i,
  input logic       de_o,
  input logic       hs_o,
  input logic       vs_o,
  input logic [2:0] drop_flag
);
  localparam int AW = $clog2(VS_MIN + 1) + 1;

  logic [1:0]    fi;
  logic [1:0]    fo;
  logic [2:0]    lo;
  logic          vs_prev;
  logic [AW-1:0] age;

  assign fi = {hs_i, de_i};
  assign fo = {hs_o, de_o};
  assign lo = {vs_o, hs_o, de_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_prev <= 1'b0;
      age     <= '0;
    end else begin
      vs_prev <= vs_o;
      if (vs_o != vs_prev)
        age <= '0;
      else if (age < AW'(VS_MIN))
        age <= age + 1'b1;
    end
  end

  // R5: consecutive vs_o changes lie at least VS_MIN edges apart
  a_r5_vs_min_gap: assert property (@(posedge clk) disable iff (rst)
    (vs_o != vs_prev) |-> (age >= AW'(VS_MIN - 1)));

  // R5: a vs_o change always takes the level sampled on vs_i
  a_r5_vs_follows: assert property (@(posedge clk) disable iff (rst)
    $changed(vs_o) |-> (vs_o == $past(vs_i)));

  for (genvar i = 0; i < 3; i++) begin : g_line
    // R7: a flag falls only after a clear pulse or a reset
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      ($fell(drop_flag[i]) && !$past(rst)) |-> $past(drop_clr[i]));

    // R6: the edge that records a drop leaves the output unchanged
    a_r6_hold_on_drop: assert property (@(posedge clk) disable iff (rst)
      $rose(drop_flag[i]) |-> $stable(lo[i]));
  end

  if (GLITCH_LEN == 3) begin : g_len3
    for (genvar j = 0; j < 2; j++) begin : g_fast
      // R2: with the qualifier on, a forwarded level was seen 3 times in a row
      a_r2_glitch_width: assert property (@(posedge clk) disable iff (rst)
        ($changed(fo[j]) && $past(glitch_en)) |->
          (($past(fi[j], 1) == fo[j]) && ($past(fi[j], 2) == fo[j]) &&
           ($past(fi[j], 3) == fo[j])));
    end
  end
endmodule

bind ctl_line_filter ctl_line_filter_chk #(
  .GLITCH_LEN (GLITCH_LEN),
  .VS_MIN     (VS_MIN)
) u_chk (.*);

// File: tb/ctl_line_filter_bench.sv
module ctl_line_filter_bench;
  localparam int WIN = 130;
  localparam int VMIN = 130;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       glitch_en = 1'b1;
  logic [2:0] drop_clr = 3'b000;
  logic       de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic       de_o, hs_o, vs_o;
  logic [2:0] drop_flag;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  bit    armed = 1'b0;
  string cur_tag = "R8";

  always #2.5 clk = ~clk;

  ctl_line_filter u_ctl_line_filter (
    .clk(clk), .rst(rst), .glitch_en(glitch_en), .drop_clr(drop_clr),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .drop_flag(drop_flag)
  );

  // Behavioural reference model
  int m_cyc;
  int m_out[3], m_flag[3], m_prevc[3], m_ws[3], m_used[3];
  int m_recent[2][$];
  int m_hold[2];
  int m_vacc, m_vrun;

  always @(posedge clk) begin
    int inb[3];
    int c;
    int bud;
    bit open, dropped;
    armed <= 1'b1;
    inb[0] = int'(de_i); inb[1] = int'(hs_i); inb[2] = int'(vs_i);
    if (rst) begin
      m_cyc = 0;
      for (int k = 0; k < 3; k++) begin
        m_out[k] = 0; m_flag[k] = 0; m_prevc[k] = 0; m_ws[k] = -1; m_used[k] = 0;
      end
      for (int k = 0; k < 2; k++) begin
        m_recent[k] = '{0, 0};
        m_hold[k] = 0;
      end
      m_vacc = 0; m_vrun = 0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (k < 2) begin
          if (!glitch_en) c = inb[k];
          else if (m_recent[k][0] == inb[k] && m_recent[k][1] == inb[k]) c = inb[k];
          else c = m_hold[k];
          m_hold[k] = c;
          m_recent[k].push_back(inb[k]);
          void'(m_recent[k].pop_front());
          bud = 2;
        end else begin
          if (inb[k] == m_vacc) begin m_vrun = 0; c = m_vacc; end
          else if (m_vrun == VMIN - 1) begin m_vacc = inb[k]; m_vrun = 0; c = inb[k]; end
          else begin m_vrun++; c = m_vacc; end
          bud = 1;
        end
        open = (m_ws[k] >= 0) && (m_cyc - m_ws[k] < WIN);
        dropped = 1'b0;
        if (c != m_prevc[k] && c != m_out[k]) begin
          if (!open) begin m_out[k] = c; m_ws[k] = m_cyc; m_used[k] = 1; end
          else if (m_used[k] < bud) begin m_out[k] = c; m_used[k]++; end
          else dropped = 1'b1;
        end
        m_prevc[k] = c;
        if (dropped) m_flag[k] = 1;
        else if (drop_clr[k]) m_flag[k] = 0;
      end
      m_cyc++;
    end
  end

  // Cycle compare against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      total++;
      if (int'(de_o) != m_out[0] || int'(hs_o) != m_out[1] || int'(vs_o) != m_out[2] ||
          int'(drop_flag[0]) != m_flag[0] || int'(drop_flag[1]) != m_flag[1] ||
          int'(drop_flag[2]) != m_flag[2]) begin
        bad++;
        $display("FAIL %s model compare: actual de/hs/vs=%b%b%b flag=%b expected %0d%0d%0d flag=%0d%0d%0d",
                 cur_tag, de_o, hs_o, vs_o, drop_flag, m_out[0], m_out[1], m_out[2],
                 m_flag[2], m_flag[1], m_flag[0]);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst = 1'b1; glitch_en = en; de_i = 0; hs_i = 0; vs_i = 0; drop_clr = 0;
    tick(3);
    chk("R8 de_o reset", de_o, 1'b0);
    chk("R8 hs_o reset", hs_o, 1'b0);
    chk("R8 vs_o reset", vs_o, 1'b0);
    chk("R8 flags reset", |drop_flag, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #(600000);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Phase 1: qualifier on
    cur_tag = "R2";
    do_reset(1'b1);
    de_i = 1;                         // N0
    tick(2); chk("R4 de before third sample", de_o, 1'b0);
    tick(1); chk("R4 de on third sample", de_o, 1'b1);
    tick(3); de_i = 0;                // N6
    tick(3); chk("R1 second de edge forwarded", de_o, 1'b0);
    tick(3); de_i = 1;                // N12
    tick(2); drop_clr = 3'b001;       // N14
    tick(1); drop_clr = 3'b000;       // N15
    chk("R6 third de edge dropped", de_o, 1'b0);
    chk("R7 set wins over clear", drop_flag[0], 1'b1);
    tick(135);                        // N150
    chk("R6 de held after window end", de_o, 1'b0);
    de_i = 0;
    tick(10); de_i = 1;               // N160
    tick(3); chk("R6 return to held level spent no budget", de_o, 1'b1);
    tick(7); hs_i = 1;                // N170
    tick(2); hs_i = 0;                // N172
    for (int i = 0; i < 6; i++) begin
      tick(1); chk("R2 two-clock hs glitch blocked", hs_o, 1'b0);
    end
    chk("R2 glitch is not a drop", drop_flag[1], 1'b0);
    tick(2); hs_i = 1;                // N180
    tick(3); hs_i = 0;                // N183
    chk("R2 three-clock hs pulse forwarded", hs_o, 1'b1);
    tick(3); chk("R2 hs return forwarded", hs_o, 1'b0);
    tick(4);                          // N190
    chk("R7 flag still set", drop_flag[0], 1'b1);
    drop_clr = 3'b001;
    tick(1); drop_clr = 3'b000;
    chk("R7 flag cleared by pulse", drop_flag[0], 1'b0);

    // Phase 2: qualifier off
    cur_tag = "R3";
    do_reset(1'b0);
    hs_i = 1;                         // N0
    tick(1); chk("R3 R4 one-clock hs high forwarded", hs_o, 1'b1);
    hs_i = 0;
    tick(1); chk("R3 one-clock hs low forwarded", hs_o, 1'b0);
    hs_i = 1;
    tick(1); chk("R1 third hs edge dropped", hs_o, 1'b0);
    chk("R7 hs flag set", drop_flag[1], 1'b1);
    hs_i = 0;                         // N3
    tick(97); drop_clr = 3'b010;      // N100
    tick(1); drop_clr = 3'b000;
    chk("R7 hs flag cleared", drop_flag[1], 1'b0);
    tick(28); hs_i = 1;               // N129, sampled on last window edge
    tick(1); chk("R1 edge on last window clock dropped", hs_o, 1'b0);
    chk("R7 hs flag set again", drop_flag[1], 1'b1);
    hs_i = 0;
    tick(1); hs_i = 1;                // N131
    tick(1); chk("R1 new window accepts edge", hs_o, 1'b1);

    // Phase 3: vertical sync persistence
    cur_tag = "R5";
    do_reset(1'b1);
    vs_i = 1;                         // N0
    tick(129); vs_i = 0;              // N129
    tick(11); chk("R5 129-clock vs level blocked", vs_o, 1'b0);
    vs_i = 1;                         // N140
    tick(129); chk("R5 vs before 130th sample", vs_o, 1'b0);
    tick(1); chk("R5 vs on 130th sample", vs_o, 1'b1);
    tick(30); vs_i = 0;               // N300
    tick(129); chk("R5 vs fall before 130th sample", vs_o, 1'b1);
    tick(1); chk("R5 vs fall on 130th sample", vs_o, 1'b0);
    chk("R5 no vs drop", drop_flag[2], 1'b0);

    // Phase 4: random patterns in both modes
    cur_tag = "R1";
    for (int mode = 0; mode < 2; mode++) begin
      int rd, rh, rv;
      do_reset(mode == 0);
      rd = 0; rh = 0; rv = 0;
      for (int n = 0; n < 4000; n++) begin
        @(negedge clk);
        if (rd == 0) begin de_i = ~de_i; rd = ($urandom % 8 == 0) ? 20 + $urandom % 150 : 1 + $urandom % 5; end
        else rd--;
        if (rh == 0) begin hs_i = ~hs_i; rh = ($urandom % 8 == 0) ? 20 + $urandom % 150 : 1 + $urandom % 5; end
        else rh--;
        if (rv == 0) begin vs_i = ~vs_i; rv = 100 + $urandom % 120; end
        else rv--;
        drop_clr = ($urandom % 40 == 0) ? 3'($urandom) : 3'b000;
      end
      @(negedge clk); drop_clr = 3'b000;
    end

    tick(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule